// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder/Subtractor

The block adds or subtracts two 32-bit binary floating-point words. Each word has a sign in bit 31, a biased exponent in bits 30:23 and a stored fraction in bits 22:0. It uses a fixed four-stage pipeline with one clock per stage. The stages, in order, are magnitude compare, mantissa alignment, shared add/subtract, and normalize with rounding. An operation enters on any clock where `valid_i` is high, and its result leaves with `valid_o` exactly four clocks later. There is no stall. The shifts for alignment and normalization are done in a single cycle by multiplexer trees, never one bit per cycle.

Subtraction does not have its own datapath. It reuses the adder by taking the two's complement of the smaller aligned operand. A runtime input `short_i` selects a narrow format with a 12-bit stored fraction. In that format the low 11 fraction bits of both inputs are cleared before use, the result is rounded at 13 significant bits, and the low 11 fraction bits of the output are zero. Subnormal values are flushed to zero, on input and on output. Rounding is to nearest, with ties going to even.

Top module: `fp_addsub_pipe`

## Requirements
- R1: A result appears on `result_o` with `valid_o` high exactly 4 rising clock edges after `valid_i` is sampled high. `valid_o` is low 4 edges after `valid_i` is sampled low. A new operation is accepted on every clock.
- R2: With `sub_i`=1 the result is a minus b: the sign of b is inverted before the operation. With `sub_i`=0 it is a plus b.
- R3: For finite nonzero inputs, the result is the exact sum rounded to nearest-even at 24 significant bits. If rounding carries out of the significand, the exponent is raised by one.
- R4: Cancellation is renormalized by a left shift with a matching lower exponent. An exact zero from operands of opposite effective sign is +0 (0x00000000). Zero plus zero with the same effective sign keeps that sign.
- R5: A rounded result with biased exponent of 255 or more becomes a signed infinity (exponent 0xFF, fraction 0).
- R6: An input with exponent field 0 counts as a zero of its sign. A rounded result with biased exponent 0 or less becomes a zero of the result's sign.
- R7: A NaN input (exponent 0xFF, nonzero fraction), or infinities of opposite effective sign, gives 0x7FC00000.
- R8: A single infinity, or two infinities of the same effective sign, gives that infinity with its effective sign.
- R9: With `short_i`=1, fraction bits 10:0 of both inputs are treated as 0 before any decode, including NaN decode. Rounding is to nearest-even at 13 significant bits, and result bits 10:0 are 0.
- R10: While `rst_ni` is low and right after it rises, `valid_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 1 selects a minus b |
| short_i | input | 1 | 1 selects the 12-bit-fraction format |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result strobe, 4 clocks after `valid_i` |
| result_o | output | 32 | Sum or difference |

## Verification
Faults in this block show up four clocks after the operation that exposes them, on that operation's own result word. Nothing is held from one operation to the next, so a corrupted stage register damages only the operation passing through it. A lost sticky bit or a wrong guard position shows as a one-ulp error on tie and near-tie cases. A bad leading-zero count shows as a wrong exponent after cancellation. A misrouted valid bit shows as a strobe in the wrong cycle, or as a missing or extra result at the end of the stream. The bench uses a wide-integer model of the exact sum to predict every word. It sweeps exponent differences and rounding patterns in both formats, and it pushes one operation per clock.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int RED_W  = 12;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIG_W  = MAN_W + 1;
  localparam int EXT_W  = SIG_W + 3;            // significand + guard, round, sticky
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam int LSB_FULL = EXT_W - 1 - MAN_W;
  localparam int LSB_RED  = EXT_W - 1 - RED_W;
  localparam int CUT_W    = MAN_W - RED_W;
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef struct packed {
    logic             vld;
    logic             red;
    logic             nan;
    logic             inf;
    logic             sgn;
    logic             eff_sub;
    logic [EXP_W-1:0] exp;
    logic [EXP_W-1:0] diff;
    logic [SIG_W-1:0] mx;
    logic [SIG_W-1:0] my;
  } cmp_t;

  typedef struct packed {
    logic             vld;
    logic             red;
    logic             nan;
    logic             inf;
    logic             sgn;
    logic             eff_sub;
    logic [EXP_W-1:0] exp;
    logic [EXT_W-1:0] ax;
    logic [EXT_W-1:0] ay;
  } aln_t;

  typedef struct packed {
    logic             vld;
    logic             red;
    logic             nan;
    logic             inf;
    logic             sgn;
    logic             eff_sub;
    logic [EXP_W-1:0] exp;
    logic [EXT_W:0]   sum;
  } sum_t;
endpackage

// File: rtl/fpa_compare.sv
module fpa_compare
  import fpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic              short_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output cmp_t              q_o
);
  logic [WORD_W-1:0] mask, am, bm;
  logic [EXP_W-1:0]  ea, eb;
  logic [MAN_W-1:0]  fa, fb;
  logic              sa, sb, a_nan, b_nan, a_inf, b_inf, swap;
  logic [SIG_W-1:0]  siga, sigb;
  cmp_t              d;

  always_comb begin
    mask  = short_i ? {{(WORD_W-CUT_W){1'b1}}, {CUT_W{1'b0}}} : '1;
    am    = a_i & mask;
    bm    = b_i & mask;
    sa    = am[WORD_W-1];
    sb    = bm[WORD_W-1] ^ sub_i;
    ea    = am[MAN_W +: EXP_W];
    eb    = bm[MAN_W +: EXP_W];
    fa    = am[MAN_W-1:0];
    fb    = bm[MAN_W-1:0];
    a_nan = (&ea) && (|fa);
    b_nan = (&eb) && (|fb);
    a_inf = (&ea) && !(|fa);
    b_inf = (&eb) && !(|fb);
    siga  = (ea == '0) ? '0 : {1'b1, fa};
    sigb  = (eb == '0) ? '0 : {1'b1, fb};
    swap  = {eb, sigb} > {ea, siga};
    d.vld     = valid_i;
    d.red     = short_i;
    d.eff_sub = sa ^ sb;
    d.sgn     = swap ? sb : sa;
    d.exp     = swap ? eb : ea;
    d.diff    = swap ? eb - ea : ea - eb;
    d.mx      = swap ? sigb : siga;
    d.my      = swap ? siga : sigb;
    d.nan     = a_nan | b_nan | (a_inf & b_inf & (sa ^ sb));
    d.inf     = a_inf | b_inf;   // larger magnitude is the infinity, so sgn is its sign
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

  // R2: subtraction always has the larger magnitude in the x slot
  p_big_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o.vld && q_o.diff == '0) |-> (q_o.mx >= q_o.my));
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmp_t c_i,
  output aln_t q_o
);
  localparam int STEPS = $clog2(EXT_W);

  logic [EXT_W-1:0] lvl [STEPS+1];
  logic             stk [STEPS+1];
  logic             far;
  aln_t             d;

  assign lvl[0] = {c_i.my, 3'b000};
  assign stk[0] = 1'b0;

  for (genvar k = 0; k < STEPS; k++) begin : g_shift
    localparam int SH = 1 << k;
    localparam logic [EXT_W-1:0] LOW = {{(EXT_W-SH){1'b0}}, {SH{1'b1}}};
    assign lvl[k+1] = c_i.diff[k] ? (lvl[k] >> SH) : lvl[k];
    assign stk[k+1] = stk[k] | (c_i.diff[k] & (|(lvl[k] & LOW)));
  end

  assign far = |c_i.diff[EXP_W-1:STEPS];

  always_comb begin
    d.vld     = c_i.vld;
    d.red     = c_i.red;
    d.nan     = c_i.nan;
    d.inf     = c_i.inf;
    d.sgn     = c_i.sgn;
    d.eff_sub = c_i.eff_sub;
    d.exp     = c_i.exp;
    d.ax      = {c_i.mx, 3'b000};
    if (far) d.ay = {{(EXT_W-1){1'b0}}, |c_i.my};
    else     d.ay = {lvl[STEPS][EXT_W-1:1], lvl[STEPS][0] | stk[STEPS]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

  // R3: a nonzero smaller operand never vanishes entirely in alignment
  p_sticky_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o.vld && $past(c_i.my) != '0) |-> (q_o.ay != '0));
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
  import fpa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  aln_t a_i,
  output sum_t q_o
);
  logic [EXT_W-1:0] yc;
  logic [EXT_W:0]   raw;
  sum_t             d;

  always_comb begin
    yc  = a_i.eff_sub ? (~a_i.ay + 1'b1) : a_i.ay;
    raw = {1'b0, a_i.ax} + {1'b0, yc};
    d.vld     = a_i.vld;
    d.red     = a_i.red;
    d.nan     = a_i.nan;
    d.inf     = a_i.inf;
    d.sgn     = a_i.sgn;
    d.eff_sub = a_i.eff_sub;
    d.exp     = a_i.exp;
    d.sum     = a_i.eff_sub ? {1'b0, raw[EXT_W-1:0]} : raw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

  // R4: difference is never negative, the borrow can be dropped
  p_no_borrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i.vld && a_i.eff_sub) |-> (a_i.ax >= a_i.ay));
endmodule

// File: rtl/fpa_normalize.sv
module fpa_normalize
  import fpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sum_t              s_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o
);
  localparam logic signed [EXP_W+1:0] E_TOP = (1 <<< EXP_W) - 1;

  logic                     carry, zero, g, st, lsb, up, ovf;
  logic [LZ_W-1:0]          lz;
  logic [EXT_W-1:0]         m, one_at, half_at;
  logic [EXT_W:0]           mr;
  logic signed [EXP_W+1:0]  e_n, e_f;
  logic [MAN_W-1:0]         frac, fmask;
  logic [WORD_W-1:0]        res_d;

  // priority encoder: highest set bit wins
  always_comb begin
    lz = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (s_i.sum[i]) lz = LZ_W'(EXT_W - 1 - i);
  end

  always_comb begin
    carry = s_i.sum[EXT_W];
    zero  = (s_i.sum == '0);
    if (carry) begin
      m   = {s_i.sum[EXT_W:2], |s_i.sum[1:0]};
      e_n = $signed({2'b00, s_i.exp}) + 10'sd1;
    end else begin
      m   = s_i.sum[EXT_W-1:0] << lz;
      e_n = $signed({2'b00, s_i.exp}) - $signed({{(EXP_W+2-LZ_W){1'b0}}, lz});
    end
    one_at  = s_i.red ? (EXT_W'(1) << LSB_RED) : (EXT_W'(1) << LSB_FULL);
    half_at = one_at >> 1;
    lsb   = |(m & one_at);
    g     = |(m & half_at);
    st    = |(m & (half_at - 1'b1));
    up    = g & (st | lsb);
    mr    = {1'b0, m} + (up ? {1'b0, one_at} : '0);
    ovf   = mr[EXT_W];
    e_f   = e_n + $signed({{(EXP_W+1){1'b0}}, ovf});
    fmask = s_i.red ? {{RED_W{1'b1}}, {CUT_W{1'b0}}} : '1;
    frac  = ovf ? '0 : (mr[EXT_W-2 -: MAN_W] & fmask);

    if (s_i.nan)                res_d = QNAN;
    else if (s_i.inf)           res_d = {s_i.sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (zero)              res_d = {s_i.sgn & ~s_i.eff_sub, {(WORD_W-1){1'b0}}};
    else if (e_f <= 10'sd0)     res_d = {s_i.sgn, {(WORD_W-1){1'b0}}};
    else if (e_f >= E_TOP)      res_d = {s_i.sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else                        res_d = {s_i.sgn, e_f[EXP_W-1:0], frac};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= s_i.vld;
      result_o <= res_d;
    end
  end

  // R7: an all-ones exponent carries either a zero fraction or the canonical NaN
  p_special_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o[MAN_W +: EXP_W] == '1) |->
      (result_o[MAN_W-1:0] == '0 || result_o == QNAN));

  // R9: narrow format leaves the cut fraction bits clear
  p_short_low_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s_i.red)) |-> (result_o[CUT_W-1:0] == '0));
endmodule

// File: rtl/fp_addsub_pipe.sv
module fp_addsub_pipe
  import fpa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sub_i,
  input  logic              short_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o
);
  cmp_t c_q;
  aln_t a_q;
  sum_t s_q;

  fpa_compare u_cmp (
    .clk_i, .rst_ni, .valid_i, .sub_i, .short_i, .a_i, .b_i, .q_o(c_q)
  );
  fpa_align u_aln (.clk_i, .rst_ni, .c_i(c_q), .q_o(a_q));
  fpa_addsub u_add (.clk_i, .rst_ni, .a_i(a_q), .q_o(s_q));
  fpa_normalize u_nrm (.clk_i, .rst_ni, .s_i(s_q), .valid_o, .result_o);

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != 3'd4) warm_q <= warm_q + 3'd1;
  end

  // R1: strobe emerges exactly four clocks after entry
  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 3'd4) |-> (valid_o == $past(valid_i, 4)));

  // R10: quiet output right after reset
  p_reset_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q < 3'd4) |-> (!valid_o && result_o == '0));
endmodule

// File: tb/tb_fp_addsub_pipe.sv
module tb_fp_addsub_pipe;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sub_i = 1'b0, short_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  always #4 clk = ~clk;  // 125 MHz

  fp_addsub_pipe dut (.clk_i(clk), .rst_ni, .valid_i, .sub_i, .short_i,
                      .a_i, .b_i, .valid_o, .result_o);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q [0:32767];
  int          tag_q [0:32767];
  logic [31:0] ain_q [0:32767];
  logic [31:0] bin_q [0:32767];
  int wr = 0, rd = 0;
  logic [3:0] vhist = '0;
  logic [31:0] rs = 32'h1234_5679;

  function automatic logic [31:0] nxt(inout logic [31:0] s);
    s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
    return s;
  endfunction

  // exact wide-integer reference, rounded once
  function automatic logic [31:0] model(input logic [31:0] a0, b0, input logic sub, red);
    logic [31:0] a, b, mask, t;
    logic [127:0] ma, mb, mag, q, rem, half;
    int ea, eb, d, p, e, sh, P;
    logic sa, sb, sr, up;
    mask = red ? 32'hFFFF_F800 : 32'hFFFF_FFFF;
    a = a0 & mask; b = b0 & mask;
    sa = a[31]; sb = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    P  = red ? 13 : 24;
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return 32'h7FC0_0000;
    if (ea == 255 && eb == 255) return (sa != sb) ? 32'h7FC0_0000 : {sa, 8'hFF, 23'h0};
    if (ea == 255) return {sa, 8'hFF, 23'h0};
    if (eb == 255) return {sb, 8'hFF, 23'h0};
    if (ea == 0 && eb == 0) return (sa == sb) ? {sa, 31'h0} : 32'h0;
    if (ea == 0) return {sb, b[30:0]};
    if (eb == 0) return {sa, a[30:0]};
    if (eb > ea) begin
      t = a; a = b; b = t; d = ea; ea = eb; eb = d; up = sa; sa = sb; sb = up;
    end
    ma = {105'h0, 1'b1, a[22:0]};
    mb = {105'h0, 1'b1, b[22:0]};
    d = ea - eb;
    if (d > 60) begin mb = 128'h1; d = 60; end
    ma = ma << d;
    if (sa == sb)      begin mag = ma + mb; sr = sa; end
    else if (ma >= mb) begin mag = ma - mb; sr = sa; end
    else               begin mag = mb - ma; sr = sb; end
    if (mag == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 128; i++) if (mag[i]) p = i;
    e = ea - d + p - 23;
    if (p >= P - 1) begin
      sh = p - (P - 1);
      q = mag >> sh;
      if (sh > 0) begin
        rem  = mag & ((128'h1 << sh) - 1);
        half = 128'h1 << (sh - 1);
        up = (rem > half) || (rem == half && q[0]);
        q = q + 128'(up);
        if (q == (128'h1 << P)) begin q = q >> 1; e = e + 1; end
      end
    end else q = mag << (P - 1 - p);
    if (e <= 0) return {sr, 31'h0};
    if (e >= 255) return {sr, 8'hFF, 23'h0};
    q = (q - (128'h1 << (P - 1))) << (24 - P);
    return {sr, 8'(e), q[22:0]};
  endfunction

  task automatic sample();
    checks++;
    if (valid_o !== vhist[3]) begin
      fails++;
      $display("FAIL R1 valid_o=%0b expected %0b", valid_o, vhist[3]);
    end
    if (valid_o === 1'b1) begin
      checks++;
      if (result_o !== exp_q[rd]) begin
        fails++;
        $display("FAIL R%0d a=%h b=%h result=%h expected %h",
                 tag_q[rd], ain_q[rd], bin_q[rd], result_o, exp_q[rd]);
      end
      rd = (rd + 1) & 32767;
    end
  endtask

  task automatic issue(input logic [31:0] a, b, input logic sub, red, input int tag);
    logic [31:0] e;
    int t;
    @(negedge clk);
    sample();
    e = model(a, b, sub, red);
    t = tag;
    if (t < 0) begin
      if (red) t = 9;
      else if (e == 32'h7FC0_0000) t = 7;
      else if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) t = 8;
      else if (e[30:23] == 8'hFF) t = 5;
      else if (e[30:23] == 8'h00) t = 6;
      else if (sub) t = 2;
      else t = 3;
    end
    valid_i = 1'b1; sub_i = sub; short_i = red; a_i = a; b_i = b;
    exp_q[wr] = e; tag_q[wr] = t; ain_q[wr] = a; bin_q[wr] = b;
    wr = (wr + 1) & 32767;
    vhist = {vhist[2:0], 1'b1};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      valid_i = 1'b0; a_i = $urandom; b_i = $urandom;
      vhist = {vhist[2:0], 1'b0};
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  logic [31:0] ra, rb;
  int          ebx, k;
  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (valid_o !== 1'b0 || result_o !== 32'h0) begin
      fails++; $display("FAIL R10 valid_o=%b result=%h expected 0 0", valid_o, result_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== 32'h0) begin
      fails++; $display("FAIL R10 after release valid_o=%b result=%h expected 0 0", valid_o, result_o);
    end

    // R1: basic sums with gaps between operations
    issue(32'h3F80_0000, 32'h4000_0000, 0, 0, 1);
    idle(2);
    issue(32'h4040_0000, 32'hBF80_0000, 0, 0, 1);
    idle(5);
    // R2: subtract flips b
    issue(32'h4040_0000, 32'h3F80_0000, 1, 0, 2);
    issue(32'h3F80_0000, 32'hC000_0000, 1, 0, 2);
    // R3: ties and near ties
    issue(32'h3F80_0000, 32'h3380_0000, 0, 0, 3);
    issue(32'h3F80_0001, 32'h3380_0000, 0, 0, 3);
    issue(32'h3F80_0000, 32'h33C0_0000, 0, 0, 3);
    issue(32'h3F80_0000, 32'h3380_0000, 1, 0, 3);
    issue(32'h3FFF_FFFF, 32'h3400_0000, 0, 0, 3);
    // R4: cancellation and zero signs
    issue(32'h4123_4567, 32'h4123_4567, 1, 0, 4);
    issue(32'hC123_4567, 32'h4123_4567, 0, 0, 4);
    issue(32'h3F80_0000, 32'h3F7F_FFFF, 1, 0, 4);
    issue(32'h8000_0000, 32'h8000_0000, 0, 0, 4);
    issue(32'h8000_0000, 32'h0000_0000, 1, 0, 4);
    issue(32'h8000_0000, 32'h0000_0000, 0, 0, 4);
    // R5: overflow
    issue(32'h7F7F_FFFF, 32'h7F7F_FFFF, 0, 0, 5);
    issue(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1, 0, 5);
    issue(32'h7F7F_FFFF, 32'h7300_0000, 0, 0, 5);
    // R6: subnormal flush and underflow
    issue(32'h0000_0001, 32'h0000_0000, 0, 0, 6);
    issue(32'h007F_FFFF, 32'h3F80_0000, 0, 0, 6);
    issue(32'h0080_0000, 32'h0080_0001, 1, 0, 6);
    issue(32'h0100_0000, 32'h00C0_0000, 1, 0, 6);
    // R7: NaN
    issue(32'h7F80_0001, 32'h3F80_0000, 0, 0, 7);
    issue(32'h3F80_0000, 32'hFFC1_2345, 1, 0, 7);
    issue(32'h7F80_0000, 32'h7F80_0000, 1, 0, 7);
    issue(32'h7F80_0000, 32'hFF80_0000, 0, 0, 7);
    // R8: infinities
    issue(32'h7F80_0000, 32'h3F80_0000, 0, 0, 8);
    issue(32'h3F80_0000, 32'h7F80_0000, 1, 0, 8);
    issue(32'hFF80_0000, 32'h7F80_0000, 1, 0, 8);
    // R9: narrow format, including a NaN that the cut bits hide
    issue(32'h3F80_0000, 32'h3980_0000, 0, 1, 9);
    issue(32'h3F80_0000, 32'h39C0_0000, 0, 1, 9);
    issue(32'h3F80_07FF, 32'h3F80_0000, 1, 1, 9);
    issue(32'h7F80_0400, 32'h3F80_0000, 0, 1, 9);
    issue(32'h4049_0FDB, 32'h402D_F854, 0, 1, 9);
    idle(6);

    // R3 R9: exponent-difference sweep with rounding-sensitive fractions, both formats
    for (int md = 0; md < 4; md++) begin
      for (int d = 0; d <= 40; d++) begin
        for (int f = 0; f < 8; f++) begin
          ra = {1'b0, 8'd130, nxt(rs)[22:0]};
          case (f)
            0: rb = {1'b0, 8'(130 - d), 23'h000000};
            1: rb = {1'b0, 8'(130 - d), 23'h7FFFFF};
            2: rb = {1'b0, 8'(130 - d), 23'h400000};
            3: rb = {1'b0, 8'(130 - d), 23'h000001};
            4: rb = {1'b0, 8'(130 - d), 23'h400800};
            5: rb = {1'b0, 8'(130 - d), ra[22:0]};
            6: rb = {1'b1, 8'(130 - d), 23'h3FF800};
            default: rb = {nxt(rs)[31], 8'(130 - d), nxt(rs)[22:0]};
          endcase
          issue(ra, rb, md[0], md[1], -1);
        end
      end
    end

    // R2 R4 R5 R6: pseudo-random stream, one operation per clock
    for (int n = 0; n < 20000; n++) begin
      ra = nxt(rs);
      k  = int'(nxt(rs) & 32'h7);
      if (k == 0) rb = nxt(rs);
      else begin
        ebx = int'(ra[30:23]) + int'(nxt(rs) % 61) - 30;
        if (ebx < 0) ebx = 0;
        if (ebx > 255) ebx = 255;
        rb = {nxt(rs)[31], 8'(ebx), (k == 1) ? ra[22:0] : nxt(rs)[22:0]};
        if (k == 2) ra[30:23] = 8'(8'd1 + (nxt(rs) & 32'h3));
        if (k == 3) begin ra[30:23] = 8'hFE; rb[30:23] = 8'hFE; end
      end
      issue(ra, rb, nxt(rs)[0], (nxt(rs) & 32'h3) == 0, -1);
    end
    idle(8);

    // R1: every issued operation produced exactly one result
    checks++;
    if (rd != wr) begin
      fails++; $display("FAIL R1 results received=%0d expected %0d", rd, wr);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule